// File: doc/BRIEF.md
# Timed pattern pulse sequencer

The block plays a preloaded program onto a bank of digital output lines. A program is a list of steps, and each step pairs an output bit pattern with a hold time counted in clock cycles. The two halves of a step sit in two on-chip tables, a duration table and a pattern table. One step pointer addresses both tables, so the two words of a step always come out together.

While the sequencer is idle, a host loads the tables through a narrow write port with no speed demands. A start pulse then launches the program, and the sequencer needs no further host help. It shows each pattern for exactly its programmed number of cycles. The next step's words are fetched during the current step, so consecutive patterns follow one another with no gap cycles.

A program ends at the first step whose duration word is zero, or after the last table slot. The block then pulses a done flag and puts the programmable idle pattern back on the outputs. An abort input stops a run at the next clock edge.

Top module: `pulse_seq_top`

## Requirements
- R1: While rst is high, and on the first cycle after it, pat_out is all zeros and busy and done are low.
- R2: While busy is low, pat_out equals the value that idle_pat had at the previous clock edge.
- R3: A write with wr_en high at an edge where busy is low stores wr_data at wr_addr. It goes to the duration table when wr_sel is 0 and to the pattern table when wr_sel is 1. Writes at edges where busy is high change neither table, and a later run shows the earlier contents.
- R4: When start is high and abort is low at an edge where busy is low, busy is high after that edge. The pattern of the step at address 0 appears on pat_out after the following edge.
- R5: A step with duration N (N ≥ 1) holds its pattern on pat_out for exactly N clock cycles. The next step's pattern appears on the cycle after, with no gap cycles.
- R6: When the step about to be loaded has a duration word of zero, the run ends instead: busy falls, done is high for that cycle, and pat_out takes the idle pattern. A zero at address 0 ends the run one cycle after busy rose.
- R7: After the step at the last address (2047 with default parameters) has finished, the run ends as in R6. The pointer does not wrap to address 0.
- R8: abort high at an edge where busy is high ends the run at that edge. busy falls, pat_out takes the idle pattern, and done stays low. abort has no effect while busy is low and, if high together with start, blocks the start.
- R9: start is ignored while busy is high. Every run begins at address 0, including a run that follows an aborted run.
- R10: done is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Table select: 0 duration, 1 pattern |
| wr_addr | input | ADDR_W (11) | Host write address |
| wr_data | input | 16 | Host write data (duration or pattern word) |
| idle_pat | input | PAT_W (16) | Pattern driven when no run is active |
| start | input | 1 | Launch a run from address 0 |
| abort | input | 1 | Stop the current run at the next edge |
| pat_out | output | PAT_W (16) | Registered output pattern |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a program ends by itself |

## Verification
busy rises one edge after an accepted start, and the first pattern appears one edge after that. Each later pattern appears exactly its duration in cycles after the previous one. The end of a run (busy low, done high, idle pattern on the outputs) lands on the edge where the next step would have loaded, and an abort takes effect on the edge that samples it. A behavioural model in the bench advances on every rising edge from the same input values as the design. The bench compares all three outputs against it a few nanoseconds after each edge, so every one of these latencies is checked on the exact cycle it is due.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int unsigned DEF_ADDR_W = 11;
    localparam int unsigned DEF_PAT_W  = 16;
    localparam int unsigned DEF_DUR_W  = 16;
    localparam int unsigned N_TABLES   = 2;

    localparam logic SEL_DUR = 1'b0;
    localparam logic SEL_PAT = 1'b1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRIME = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // True when the pointer has moved past the last table slot or the
    // fetched duration word marks the end of the program.
    function automatic logic prog_over(input logic past_last, input logic dur_zero);
        return past_last | dur_zero;
    endfunction

endpackage

// File: rtl/pseq_table.sv
module pseq_table #(
    parameter int unsigned AW = 11,
    parameter int unsigned W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] q_dur,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic          lat_load,
    output logic          lat_idle
);
    phase_e        ph_q, ph_d;
    logic [AW:0]   ptr_q, ptr_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          done_d;
    logic          step_due;
    logic          over;

    assign over     = prog_over(ptr_q[AW], q_dur == '0);
    assign step_due = (ph_q == PH_PRIME) || ((ph_q == PH_RUN) && (cnt_q == DW'(1)));

    always_comb begin
        ph_d     = ph_q;
        ptr_d    = ptr_q;
        cnt_d    = cnt_q;
        done_d   = 1'b0;
        lat_load = 1'b0;
        lat_idle = 1'b0;
        if (ph_q == PH_IDLE) begin
            lat_idle = 1'b1;
            if (start && !abort) begin
                ph_d  = PH_PRIME;
                ptr_d = '0;
            end
        end else if (abort) begin
            ph_d     = PH_IDLE;
            lat_idle = 1'b1;
        end else if (step_due) begin
            if (over) begin
                ph_d     = PH_IDLE;
                lat_idle = 1'b1;
                done_d   = 1'b1;
            end else begin
                lat_load = 1'b1;
                cnt_d    = q_dur;
                ptr_d    = ptr_q + (AW+1)'(1);
                ph_d     = PH_RUN;
            end
        end else begin
            cnt_d = cnt_q - DW'(1);
        end
    end

    // The tables register their read data, so they are addressed with the
    // pointer's next value: the word of the pending step is ready one edge later.
    assign rd_addr = ptr_d[AW-1:0];
    assign busy    = (ph_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            ptr_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
            done  <= done_d;
        end
    end
endmodule

// File: rtl/pseq_outlatch.sv
module pseq_outlatch #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lat_idle,
    input  logic          lat_load,
    input  logic [PW-1:0] idle_pat,
    input  logic [PW-1:0] step_pat,
    output logic [PW-1:0] pat_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_out <= '0;
        end else if (lat_idle) begin
            pat_out <= idle_pat;
        end else if (lat_load) begin
            pat_out <= step_pat;
        end
    end
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top
    import pseq_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PAT_W  = DEF_PAT_W,
    parameter int unsigned DUR_W  = DEF_DUR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [PAT_W-1:0]  idle_pat,
    input  logic              start,
    input  logic              abort,
    output logic [PAT_W-1:0]  pat_out,
    output logic              busy,
    output logic              done
);
    localparam int unsigned TW = (PAT_W > DUR_W) ? PAT_W : DUR_W;

    logic [ADDR_W-1:0] rd_addr;
    logic [TW-1:0]     tab_q [N_TABLES];
    logic [TW-1:0]     wdata_ext;
    logic              lat_load, lat_idle;

    assign wdata_ext = TW'(wr_data);

    for (genvar t = 0; t < N_TABLES; t++) begin : g_tab
        localparam int unsigned TWID = (t == 0) ? DUR_W : PAT_W;
        logic [TWID-1:0] q;
        logic            we_t;
        assign we_t = wr_en && !busy && (wr_sel == ((t == 0) ? SEL_DUR : SEL_PAT));
        pseq_table #(.AW(ADDR_W), .W(TWID)) u_tab (
            .clk   (clk),
            .we    (we_t),
            .waddr (wr_addr),
            .wdata (wdata_ext[TWID-1:0]),
            .raddr (rd_addr),
            .rdata (q)
        );
        assign tab_q[t] = TW'(q);
    end

    pseq_ctrl #(.AW(ADDR_W), .DW(DUR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .q_dur    (tab_q[0][DUR_W-1:0]),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .done     (done),
        .lat_load (lat_load),
        .lat_idle (lat_idle)
    );

    pseq_outlatch #(.PW(PAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .lat_idle (lat_idle),
        .lat_load (lat_load),
        .idle_pat (idle_pat),
        .step_pat (tab_q[1][PAT_W-1:0]),
        .pat_out  (pat_out)
    );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
    parameter int unsigned PAT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             abort,
    input logic [PAT_W-1:0] idle_pat,
    input logic [PAT_W-1:0] pat_out,
    input logic             busy,
    input logic             done
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                  // R6

    AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !done));                            // R8

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !abort) |=> busy);                             // R4

    AST_BUSY_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && (!start || abort)) |=> !busy);                          // R9

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (pat_out == $past(idle_pat)));                          // R2

    AST_END_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || $past(abort)));                          // R6
endmodule

bind pulse_seq_top pseq_checker #(.PAT_W(PAT_W)) u_pseq_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (abort),
    .idle_pat (idle_pat),
    .pat_out  (pat_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_pulse_seq_top.sv
`timescale 1ns/1ps
module tb_pulse_seq_top;
    localparam int DEPTH = 2048;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] idle_pat = 16'h0000;
    logic        start = 1'b0, abort = 1'b0;
    logic [15:0] pat_out;
    logic        busy, done;

    always #4 clk = ~clk;   // 125 MHz

    pulse_seq_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .idle_pat(idle_pat), .start(start), .abort(abort),
        .pat_out(pat_out), .busy(busy), .done(done)
    );

    // ---------------- reference model ----------------
    int unsigned m_dur [DEPTH];
    int unsigned m_pat [DEPTH];
    int          m_ptr = 0;
    int          m_cnt = 0;
    bit          m_prime = 0;
    bit          m_busy = 0, m_done = 0;
    logic [15:0] m_out = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_out = '0; m_prime = 0;
        end else begin
            if (wr_en && !m_busy) begin
                if (wr_sel) m_pat[wr_addr] = wr_data;
                else        m_dur[wr_addr] = wr_data;
            end
            m_done = 0;
            if (!m_busy) begin
                m_out = idle_pat;
                if (start && !abort) begin
                    m_busy = 1; m_ptr = 0; m_prime = 1;
                end
            end else if (abort) begin
                m_busy = 0; m_out = idle_pat;
            end else if (m_prime || m_cnt == 1) begin
                if (m_ptr >= DEPTH || m_dur[m_ptr] == 0) begin
                    m_busy = 0; m_done = 1; m_out = idle_pat;
                end else begin
                    m_out = m_pat[m_ptr][15:0];
                    m_cnt = m_dur[m_ptr];
                    m_ptr++;
                    m_prime = 0;
                end
            end else begin
                m_cnt--;
            end
        end
    end

    // ---------------- checking ----------------
    int    vectors = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog %s: got %0d cycles exp at most %0d", cur_req, cycles, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic compare();
        vectors++;
        if (pat_out !== m_out) begin
            errors++;
            $display("FAIL %s pat_out: got %h exp %h", cur_req, pat_out, m_out);
        end
        if (busy !== m_busy) begin
            errors++;
            $display("FAIL %s busy: got %b exp %b", cur_req, busy, m_busy);
        end
        if (done !== m_done) begin
            errors++;
            $display("FAIL %s/R10 done: got %b exp %b", cur_req, done, m_done);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #3;
        compare();
    endtask

    task automatic wr(input logic sel, input int addr, input int data);
        wr_en = 1'b1; wr_sel = sel; wr_addr = 11'(addr); wr_data = 16'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic run_out();
        for (int i = 0; i < 5000 && m_busy; i++) tick();
        tick();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R2: idle output follows idle_pat one edge later
        cur_req = "R2";
        idle_pat = 16'hA5A5; tick(); tick();
        idle_pat = 16'h0F0F; tick();
        abort = 1'b1; tick(); abort = 1'b0;       // R8: abort while idle, no effect
        idle_pat = 16'h00FF; tick();

        // R3: program durations 3,1,2,5 then end marker
        cur_req = "R3";
        wr(0, 0, 3); wr(1, 0, 16'h1111);
        wr(0, 1, 1); wr(1, 1, 16'h2222);
        wr(0, 2, 2); wr(1, 2, 16'h3333);
        wr(0, 3, 5); wr(1, 3, 16'h4444);
        wr(0, 4, 0); wr(1, 4, 16'hDEAD);

        // R4, R5, R6: full run
        cur_req = "R5";
        go();
        run_out();

        // R3: writes while busy are ignored; R9: start while busy ignored
        cur_req = "R3";
        go();
        wr(1, 1, 16'hBEEF);
        wr(0, 2, 9);
        cur_req = "R9";
        start = 1'b1; tick(); start = 1'b0;
        run_out();
        cur_req = "R3";
        go();                 // rerun shows unchanged contents
        run_out();

        // R8: abort mid run, then restart from address 0 (R9)
        cur_req = "R8";
        idle_pat = 16'h5A5A;
        go();
        tick(); tick();
        abort = 1'b1; tick(); abort = 1'b0;
        tick();
        start = 1'b1; abort = 1'b1; tick(); start = 1'b0; abort = 1'b0;   // blocked start
        tick();
        cur_req = "R9";
        go();
        run_out();
        cur_req = "R8";
        go();
        abort = 1'b1; tick(); abort = 1'b0;       // abort in first cycle of run
        tick();

        // R6: zero duration at address 0
        cur_req = "R6";
        wr(0, 0, 0);
        go();
        tick(); tick();

        // R7: every slot filled with duration 1 and a distinct pattern
        cur_req = "R7";
        for (int a = 0; a < DEPTH; a++) begin
            wr(0, a, 1);
            wr(1, a, (a * 37 + 5) & 16'hFFFF);
        end
        wr(0, 100, 2);
        go();
        run_out();
        tick();

        // R10 covered by the done compare on every vector
        cur_req = "R10";
        repeat (3) tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule